// File: doc/BRIEF.md
# Decimal Effective Address Unit

This unit sits between the decode and execute stages of a small machine that works in three-digit decimal words, each digit held as a 4-bit BCD nibble. The unit owns the ten general-purpose registers. On each request it turns an operand field into one of three things: an operand value, a register target, or a memory address. The operand field is a mode digit followed by a two-digit register number, and a request may also carry a three-digit displacement word. The unit applies any register side effect from the addressing mode. For indirect modes it also performs one pointer read from main memory.

The mode digit picks one of five base modes: register, immediate, base-plus-displacement, predecrement or postincrement. An odd mode digit selects the indirect form of that base mode. The direct forms finish in a single cycle. An indirect form holds a memory read request until memory answers, and the address returned is the word read back. The execute stage drives a request pulse and waits for the done strobe. A separate write-back port lets the execute stage load registers.

Top module: `dec_ea_unit`

## Requirements
- R1: The operand field is three BCD digits. Bits [11:8] hold the mode digit and bits [7:0] hold the register number (tens digit in [7:4], units digit in [3:0]). Mode digit m selects base mode m/2, and an odd m selects the indirect form. The base modes are 0 register, 1 immediate, 2 base, 3 predecrement and 4 postincrement. Result kinds are 0 operand value, 1 register target and 2 memory address.
- R2: After reset every register reads 000, and both `o_done` and `o_mem_rd` are low.
- R3: Register direct (mode 0), when accepted, raises `o_done` one cycle later. A read returns kind 0 with the register contents. A write returns kind 1 with the register number in the low two digits.
- R4: Immediate direct (mode 2) on a read returns kind 0 with the displacement word, and the register digits are ignored (even 10–99 raise no error). Immediate as a write destination is an error.
- R5: Base direct (mode 4) returns kind 2 with address register + displacement, computed in decimal modulo 1000.
- R6: Predecrement (modes 6 and 7) lowers the register by one, modulo 1000 (000 becomes 999), when the request is accepted. The pointer is the decremented value.
- R7: Postincrement (modes 8 and 9) uses the old register value as the pointer and stores that value plus one, modulo 1000 (999 becomes 000).
- R8: Indirect forms (odd modes; immediate indirect uses the displacement as pointer) raise `o_mem_rd` the cycle after acceptance and hold it, with a stable `o_mem_addr` equal to the pointer, until `i_mem_ready`. One cycle after ready the unit returns kind 2 with the read word and no error. Direct forms issue no memory read.
- R9: A mode digit above 9, or a register number of 10 or more in any mode other than immediate, gives `o_done` with `o_err` one cycle after acceptance. No register changes and no memory read is issued.
- R10: A request that arrives while an indirect read is pending is ignored: no register changes and no extra done strobe.
- R11: The write-back port loads register `i_wb_idx` (indices 10–15 are ignored) at the clock edge. When a mode side effect targets the same register in the same cycle, the side effect wins.
- R12: `o_done` is a single-cycle strobe per accepted request, and `o_err` is only high together with `o_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | 1 | Request strobe, accepted when no read is pending |
| i_field | input | 12 | Operand field: mode digit and two register digits, BCD |
| i_disp | input | 12 | Displacement / immediate word, BCD |
| i_write | input | 1 | 1 = destination operand, 0 = source operand |
| o_done | output | 1 | Result valid strobe |
| o_err | output | 1 | Addressing error, with o_done |
| o_kind | output | 2 | Result kind: 0 value, 1 register target, 2 memory address |
| o_val | output | 12 | Result value, register number or address, BCD |
| o_mem_rd | output | 1 | Pointer read request |
| o_mem_addr | output | 12 | Pointer read address, BCD |
| i_mem_ready | input | 1 | Memory answer valid |
| i_mem_data | input | 12 | Word read from memory, BCD |
| i_wb_en | input | 1 | Register write-back enable |
| i_wb_idx | input | 4 | Write-back register index |
| i_wb_data | input | 12 | Write-back data, BCD |

## Verification
The checker watches the handshake on every cycle. It confirms that an even mode digit completes one cycle after acceptance without a memory read. It confirms that a pending read keeps its address steady and blocks any done strobe until ready, that ready leads to a clean memory-kind result, and that errors only appear on the done strobe. The decimal arithmetic is covered only by the bench scenarios, which compare results against a model of the register file: the base sum, wrap at 000/999, predecrement and postincrement values, and the ignored register digits of immediate mode. The same applies to the facts that error and busy requests leave registers untouched and that a side effect beats a same-cycle write-back.

// File: rtl/dec_ea_pkg.sv
package dec_ea_pkg;
    typedef enum logic [1:0] {
        KIND_VAL = 2'd0,
        KIND_REG = 2'd1,
        KIND_MEM = 2'd2
    } res_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RD   = 1'b1
    } ea_state_e;

    // base mode = mode digit / 2
    localparam logic [2:0] BM_REG  = 3'd0;
    localparam logic [2:0] BM_IMM  = 3'd1;
    localparam logic [2:0] BM_BASE = 3'd2;
    localparam logic [2:0] BM_PRE  = 3'd3;
    localparam logic [2:0] BM_POST = 3'd4;
endpackage

// File: rtl/dec_bcd_digit.sv
module dec_bcd_digit (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       sub,
    input  logic       cin,
    output logic [3:0] s,
    output logic       cout
);
    logic [3:0] b_eff;
    logic [4:0] raw;
    logic [4:0] adj;

    always_comb begin
        b_eff = sub ? (4'd9 - b) : b;
        raw   = {1'b0, a} + {1'b0, b_eff} + {4'd0, cin};
        adj   = raw + 5'd6;
        if (raw > 5'd9) begin
            s    = adj[3:0];
            cout = 1'b1;
        end else begin
            s    = raw[3:0];
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/dec_bcd_adder.sv
module dec_bcd_adder #(
    parameter int NDIG = 3,
    localparam int W   = 4 * NDIG
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] s
);
    logic [NDIG:0] carry;
    assign carry[0] = sub;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        dec_bcd_digit u_dig (
            .a   (a[4*g +: 4]),
            .b   (b[4*g +: 4]),
            .sub (sub),
            .cin (carry[g]),
            .s   (s[4*g +: 4]),
            .cout(carry[g+1])
        );
    end

    logic unused_carry;
    assign unused_carry = carry[NDIG];
endmodule

// File: rtl/dec_ea_regfile.sv
module dec_ea_regfile #(
    parameter int NREG = 10,
    parameter int W    = 12,
    localparam int IW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          se_en,
    input  logic [IW-1:0] se_idx,
    input  logic [W-1:0]  se_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data
);
    logic [W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (se_en && se_idx == IW'(g)) begin
                regs_q[g] <= se_data;
            end else if (wb_en && wb_idx == IW'(g)) begin
                regs_q[g] <= wb_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IW'(i)) rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/dec_ea_unit.sv
module dec_ea_unit #(
    parameter int NDIG = 3,
    parameter int NREG = 10,
    localparam int W   = 4 * NDIG,
    localparam int RW  = W - 4,
    localparam int IW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_req,
    input  logic [W-1:0]  i_field,
    input  logic [W-1:0]  i_disp,
    input  logic          i_write,
    output logic          o_done,
    output logic          o_err,
    output logic [1:0]    o_kind,
    output logic [W-1:0]  o_val,
    output logic          o_mem_rd,
    output logic [W-1:0]  o_mem_addr,
    input  logic          i_mem_ready,
    input  logic [W-1:0]  i_mem_data,
    input  logic          i_wb_en,
    input  logic [IW-1:0] i_wb_idx,
    input  logic [W-1:0]  i_wb_data
);
    import dec_ea_pkg::*;

    localparam logic [3:0] NREG_D = 4'(NREG);
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        ea_state_e    st;
        logic [W-1:0] addr;
        logic [W-1:0] val;
        res_kind_e    kind;
        logic         err;
        logic         done;
    } ea_regs_t;

    ea_regs_t q, d;

    logic [3:0]    mode;
    logic [RW-1:0] rdig;
    logic [2:0]    bmode;
    logic          ind, uses_reg, rn_ok, bad;
    logic [W-1:0]  r_val, sum_bd, r_dec, r_inc, ptr;
    logic          se_en;
    logic [W-1:0]  se_data;

    assign mode  = i_field[W-1 -: 4];
    assign rdig  = i_field[RW-1:0];
    assign bmode = mode[3:1];
    assign ind   = mode[0];

    dec_ea_regfile #(.NREG(NREG), .W(W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rdig[IW-1:0]),
        .rd_data(r_val),
        .se_en  (se_en),
        .se_idx (rdig[IW-1:0]),
        .se_data(se_data),
        .wb_en  (i_wb_en),
        .wb_idx (i_wb_idx),
        .wb_data(i_wb_data)
    );

    dec_bcd_adder #(.NDIG(NDIG)) u_add_base (.a(r_val), .b(i_disp), .sub(1'b0), .s(sum_bd));
    dec_bcd_adder #(.NDIG(NDIG)) u_add_dec  (.a(r_val), .b(ONE),    .sub(1'b1), .s(r_dec));
    dec_bcd_adder #(.NDIG(NDIG)) u_add_inc  (.a(r_val), .b(ONE),    .sub(1'b0), .s(r_inc));

    always_comb begin
        uses_reg = (bmode != BM_IMM);
        rn_ok    = (rdig[RW-1:4] == '0) && (rdig[3:0] < NREG_D);
        bad      = (mode > 4'd9) || (uses_reg && !rn_ok) || (i_write && mode == 4'd2);

        unique case (bmode)
            BM_IMM:  ptr = i_disp;
            BM_BASE: ptr = sum_bd;
            BM_PRE:  ptr = r_dec;
            default: ptr = r_val;
        endcase

        se_en   = i_req && (q.st == ST_IDLE) && !bad &&
                  (bmode == BM_PRE || bmode == BM_POST);
        se_data = (bmode == BM_PRE) ? r_dec : r_inc;

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (i_req) begin
                    if (bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.kind = KIND_VAL;
                        d.val  = '0;
                    end else if (ind) begin
                        d.st   = ST_RD;
                        d.addr = ptr;
                    end else begin
                        d.done = 1'b1;
                        if (bmode == BM_REG) begin
                            d.kind = i_write ? KIND_REG : KIND_VAL;
                            d.val  = i_write ? W'(rdig) : r_val;
                        end else if (bmode == BM_IMM) begin
                            d.kind = KIND_VAL;
                            d.val  = i_disp;
                        end else begin
                            d.kind = KIND_MEM;
                            d.val  = ptr;
                        end
                    end
                end
            end
            ST_RD: begin
                if (i_mem_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.kind = KIND_MEM;
                    d.val  = i_mem_data;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, val: '0, kind: KIND_VAL, err: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign o_done     = q.done;
    assign o_err      = q.err;
    assign o_kind     = q.kind;
    assign o_val      = q.val;
    assign o_mem_rd   = (q.st == ST_RD);
    assign o_mem_addr = q.addr;
endmodule

// File: rtl/dec_ea_unit_chk.sv
module dec_ea_unit_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         i_req,
    input logic [W-1:0] i_field,
    input logic         o_done,
    input logic         o_err,
    input logic [1:0]   o_kind,
    input logic         o_mem_rd,
    input logic [W-1:0] o_mem_addr,
    input logic         i_mem_ready
);
    // R3/R9: even mode digit finishes next cycle without a memory read
    p_even_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && !o_mem_rd && !i_field[W-4]) |=> (o_done && !o_mem_rd));

    // R8: any accepted request ends in either done or a pending read
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && !o_mem_rd) |=> (o_done || o_mem_rd));

    // R8: address held while waiting
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_mem_rd && !i_mem_ready) |=> (o_mem_rd && $stable(o_mem_addr)));

    // R8: ready gives a clean memory-kind result
    p_ready_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_mem_rd && i_mem_ready) |=> (o_done && !o_err && !o_mem_rd && o_kind == 2'd2));

    // R10: no done strobe while a read is pending
    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_mem_rd && !i_mem_ready) |=> !o_done);

    // R12: error only on the done strobe
    p_err_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        o_err |-> o_done);

    // R9: an error result leaves no read pending
    p_err_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_err) |-> !o_mem_rd);
endmodule

bind dec_ea_unit dec_ea_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_req      (i_req),
    .i_field    (i_field),
    .o_done     (o_done),
    .o_err      (o_err),
    .o_kind     (o_kind),
    .o_mem_rd   (o_mem_rd),
    .o_mem_addr (o_mem_addr),
    .i_mem_ready(i_mem_ready)
);

// File: tb/dec_ea_unit_bench.sv
module dec_ea_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_req = 1'b0;
    logic [11:0] i_field = '0;
    logic [11:0] i_disp = '0;
    logic        i_write = 1'b0;
    logic        o_done, o_err, o_mem_rd;
    logic [1:0]  o_kind;
    logic [11:0] o_val, o_mem_addr;
    logic        i_mem_ready = 1'b0;
    logic [11:0] i_mem_data = '0;
    logic        i_wb_en = 1'b0;
    logic [3:0]  i_wb_idx = '0;
    logic [11:0] i_wb_data = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int m_reg [10];

    always #4 clk = ~clk;

    dec_ea_unit u_dec_ea_unit (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_field(i_field), .i_disp(i_disp),
        .i_write(i_write), .o_done(o_done), .o_err(o_err), .o_kind(o_kind), .o_val(o_val),
        .o_mem_rd(o_mem_rd), .o_mem_addr(o_mem_addr), .i_mem_ready(i_mem_ready),
        .i_mem_data(i_mem_data), .i_wb_en(i_wb_en), .i_wb_idx(i_wb_idx), .i_wb_data(i_wb_data)
    );

    function automatic logic [11:0] bcd(input int v);
        return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic int memf(input int a);
        return (a * 37 + 11) % 1000;
    endfunction

    function automatic string tagof(input int mode, input bit err);
        if (err) return "R9";
        if (mode % 2 == 1) return "R8";
        case (mode / 2)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wb(input int idx, input int v);
        @(negedge clk);
        i_wb_en = 1'b1; i_wb_idx = 4'(idx); i_wb_data = bcd(v);
        @(negedge clk);
        i_wb_en = 1'b0;
        if (idx < 10) m_reg[idx] = v;
    endtask

    // one request; coll: same-cycle write-back of coll_v to the same register
    task automatic run(input string tag_in, input int mode, input int rn, input int dsp,
                       input bit wr, input int delay, input bit poke,
                       input bit coll, input int coll_v);
        int r, b, ptr, ekind, evalue;
        bit usesr, err;
        string tag;
        r     = (rn < 10) ? m_reg[rn] : 0;
        b     = mode / 2;
        usesr = (b != 1);
        err   = (mode > 9) || (usesr && rn > 9) || (wr && mode == 2);
        case (b)
            1: ptr = dsp;
            2: ptr = (r + dsp) % 1000;
            3: ptr = (r + 999) % 1000;
            default: ptr = r;
        endcase
        tag = (tag_in == "") ? tagof(mode, err) : tag_in;

        @(negedge clk);
        i_field = {4'(mode), bcd(rn)[7:0]};
        i_disp  = bcd(dsp);
        i_write = wr;
        i_req   = 1'b1;
        if (coll) begin
            i_wb_en = 1'b1; i_wb_idx = 4'(rn); i_wb_data = bcd(coll_v);
        end
        @(negedge clk);
        i_req = 1'b0;
        i_wb_en = 1'b0;
        if (coll && rn < 10) m_reg[rn] = coll_v;
        if (!err && b == 3) m_reg[rn] = (r + 999) % 1000;
        if (!err && b == 4) m_reg[rn] = (r + 1) % 1000;

        if (err) begin
            ekind = 0; evalue = 0;
        end else if (mode % 2 == 1) begin
            ekind = 2; evalue = memf(ptr);
        end else if (b == 0) begin
            ekind = wr ? 1 : 0; evalue = wr ? rn : r;
        end else if (b == 1) begin
            ekind = 0; evalue = dsp;
        end else begin
            ekind = 2; evalue = ptr;
        end

        if (!err && mode % 2 == 1) begin
            check(tag, o_mem_rd && !o_done && o_mem_addr == bcd(ptr), "read address",
                  int'(o_mem_addr), int'(bcd(ptr)));
            for (int k = 0; k < delay; k++) begin
                if (poke && k == 0) begin
                    i_field = {4'd6, 8'h00}; i_write = 1'b0; i_req = 1'b1;
                end
                @(negedge clk);
                i_req = 1'b0;
                check(poke ? "R10" : tag, o_mem_rd && !o_done && o_mem_addr == bcd(ptr),
                      "read held", int'(o_done), 0);
            end
            i_mem_ready = 1'b1;
            i_mem_data  = bcd(memf(ptr));
            @(negedge clk);
            i_mem_ready = 1'b0;
        end else begin
            check(tag, !o_mem_rd, "no memory read", int'(o_mem_rd), 0);
        end
        check(tag, o_done && o_err == err, "done/err", int'({o_done, o_err}), int'({1'b1, err}));
        check(tag, o_kind == 2'(ekind) && (err || o_val == bcd(evalue)), "kind/value",
              int'({o_kind, o_val}), int'({2'(ekind), bcd(evalue)}));
        @(negedge clk);
        check("R12", !o_done && !o_err, "strobe width", int'({o_done, o_err}), 0);
    endtask

    task automatic verify_regs(input string tag);
        for (int n = 0; n < 10; n++) run(tag, 0, n, 0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        for (int n = 0; n < 10; n++) m_reg[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", !o_done && !o_mem_rd, "reset outputs", int'({o_done, o_mem_rd}), 0);
        verify_regs("R2");

        // write-back and register direct
        wb(4, 321);
        wb(12, 555);                                   // R11: index out of range ignored
        run("R11", 0, 4, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R3", 0, 7, 0, 1'b1, 0, 1'b0, 1'b0, 0);    // register target kind 1

        // immediate: register digits ignored, write is an error
        run("R4", 2, 57, 777, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R4", 2, 3, 12, 1'b1, 0, 1'b0, 1'b0, 0);

        // base with decimal wrap
        wb(1, 950);
        run("R5", 4, 1, 75, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R5", 4, 1, 49, 1'b0, 0, 1'b0, 1'b0, 0);

        // predecrement from 000, postincrement from 999
        run("R6", 6, 2, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R6", 0, 2, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        wb(3, 999);
        run("R7", 8, 3, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R7", 0, 3, 0, 1'b0, 0, 1'b0, 1'b0, 0);

        // indirect forms
        run("R8", 5, 1, 20, 1'b0, 3, 1'b0, 1'b0, 0);
        run("R8", 1, 4, 0, 1'b1, 0, 1'b0, 1'b0, 0);
        run("R8", 3, 88, 404, 1'b0, 2, 1'b0, 1'b0, 0);
        run("R8", 9, 3, 0, 1'b0, 1, 1'b0, 1'b0, 0);

        // errors leave registers untouched
        run("R9", 4, 12, 5, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R9", 8, 10, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R9", 7, 99, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R9", 12, 1, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        verify_regs("R9");

        // busy request ignored
        wb(0, 500);
        run("R10", 7, 4, 0, 1'b0, 3, 1'b1, 1'b0, 0);
        run("R10", 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0);

        // side effect beats same-cycle write-back; plain write-back otherwise
        run("R11", 6, 5, 0, 1'b0, 0, 1'b0, 1'b1, 123);
        run("R11", 0, 5, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        run("R11", 0, 6, 0, 1'b0, 0, 1'b0, 1'b1, 444);
        run("R11", 0, 6, 0, 1'b0, 0, 1'b0, 1'b0, 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int mode, rn;
            mode = ($urandom % 20 == 0) ? 10 + int'($urandom % 6) : int'($urandom % 10);
            rn   = ($urandom % 8 == 0) ? 10 + int'($urandom % 90) : int'($urandom % 10);
            if ($urandom % 6 == 0) wb(int'($urandom % 10), int'($urandom % 1000));
            run("", mode, rn, int'($urandom % 1000), 1'($urandom % 2),
                int'($urandom % 4), 1'b0, 1'b0, 0);
        end
        verify_regs("R1");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule